// File: doc/BRIEF.md
# Programmable Swallow Counter

This block is the swallow counter of a pulse-swallow integer-N divider. It runs on the fast clock, and a clock-enable pulse arrives once per output period of the dual-modulus prescaler. A reload strobe comes from the main counter at the start of each division cycle. On that strobe the block takes a 6-bit swallow value and lowers its modulus-control output, so the prescaler divides by its higher ratio. It then counts prescaler periods down to zero. At zero it raises the modulus-control output, which sends the prescaler to its lower ratio until the next reload.

The largest swallow value allowed depends on the band select. The low band allows up to 31 and the high band allows up to 47. A value above the limit is replaced by the limit, and a sticky error flag is set. The count is held in synchronous loadable bit-cells. Each cell loads its program bit on a reload, toggles as a divide-by-two stage while counting, and holds still once the modulus output is high.

Top module: `swallow_counter`

## Requirements
- R1: An active-low reset clears the count, drives `mod_out` low and clears `range_err`.
- R2: On a clock edge where `ce` and `reload` are both high, the counter loads the swallow value (clamped per R6). `mod_out` goes low after that edge when the loaded value is nonzero. A reload in the middle of a count restarts the count from the new value.
- R3: After a load of nonzero value V, `mod_out` rises on exactly the V-th later edge that has `ce` high and `reload` low. Edges with `ce` low are not counted.
- R4: Once `mod_out` is high, it stays high and the count holds still on every `ce` edge until the next reload.
- R5: A load of value 0 drives `mod_out` high right after the loading edge, so the whole division cycle uses the lower ratio.
- R6: With `band_hi` low the limit is 31, and with `band_hi` high the limit is 47. A swallow value above the limit is loaded as the limit. The count never exceeds 47.
- R7: A load of a value above the limit sets `range_err`. The flag stays high through later in-range loads, and only reset clears it.
- R8: While `ce` is low, no input changes `mod_out`, the count or `range_err`. This includes `reload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Prescaler output pulse, one clock wide |
| swallow_val | input | 6 | Programmed swallow count |
| band_hi | input | 1 | Band select: 0 limits the count to 31, 1 limits it to 47 |
| reload | input | 1 | Cycle-start strobe from the main counter |
| mod_out | output | 1 | Modulus control: 0 selects the higher prescaler ratio, 1 selects the lower |
| range_err | output | 1 | Sticky flag for an out-of-range swallow value |

## Verification
Swallow values of 1, 5, 31, 40 and 47 count to different lengths. They separate a correct borrow chain from one that mis-toggles an upper bit, because 31 and 47 cross several bit boundaries. A value of 0 separates immediate assertion from a one-period delay. The values 32, 48 and 63 apply the band clamp and the error flag, and they separate the two limits from each other. The remaining directed patterns cover a reload during a count, gaps in the enable, and reloads presented with the enable low. These show that only enabled edges move the state.

// File: rtl/swallow_counter.sv
module swallow_counter #(
  parameter int WIDTH  = 6,
  parameter int LO_MAX = 31,
  parameter int HI_MAX = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] swallow_val,
  input  logic             band_hi,
  input  logic             reload,
  output logic             mod_out,
  output logic             range_err
);
  localparam logic [WIDTH-1:0] LO_LIM = WIDTH'(LO_MAX);
  localparam logic [WIDTH-1:0] HI_LIM = WIDTH'(HI_MAX);

  logic [WIDTH-1:0] cnt, limit, load_val, borrow;
  logic             over, load_now, step_now, nz, mod_r, err_r;

  assign limit    = band_hi ? HI_LIM : LO_LIM;
  assign over     = swallow_val > limit;
  assign load_val = over ? limit : swallow_val;
  assign load_now = ce & reload;
  assign step_now = ce & ~reload & ~mod_r;
  assign nz       = |cnt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      assign borrow[i] = 1'b1;
    end else begin : g_up
      assign borrow[i] = borrow[i-1] & ~cnt[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt[i] <= 1'b0;
      else if (load_now)                 cnt[i] <= load_val[i];
      else if (step_now && nz && borrow[i]) cnt[i] <= ~cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mod_r <= 1'b0;
    else if (load_now) mod_r <= (load_val == '0);
    else if (step_now) mod_r <= (cnt <= WIDTH'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_r <= 1'b0;
    else if (load_now && over) err_r <= 1'b1;
  end

  assign mod_out   = mod_r;
  assign range_err = err_r;
endmodule

module swallow_counter_chk #(
  parameter int WIDTH  = 6,
  parameter int HI_MAX = 47
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             reload,
  input logic [WIDTH-1:0] swallow_val,
  input logic [WIDTH-1:0] cnt,
  input logic             mod_out,
  input logic             range_err
);
  AST_LOAD_CLEARS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && reload && swallow_val != '0) |=> !mod_out); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !reload && !mod_out && cnt != '0) |=> (cnt == $past(cnt) - WIDTH'(1))); // R3
  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_out && !(ce && reload)) |=> (mod_out && $stable(cnt))); // R4
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && reload && swallow_val == '0) |=> mod_out); // R5
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= WIDTH'(HI_MAX)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(mod_out) && $stable(cnt) && $stable(range_err))); // R8
endmodule

bind swallow_counter swallow_counter_chk #(.WIDTH(WIDTH), .HI_MAX(HI_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .reload(reload), .swallow_val(swallow_val),
  .cnt(cnt), .mod_out(mod_out), .range_err(range_err)
);

// File: tb/sim_swallow_counter.sv
`timescale 1ns/1ps
module sim_swallow_counter;
  logic       clk = 1'b0, rst_n = 1'b0, ce = 1'b0, band_hi = 1'b0, reload = 1'b0;
  logic [5:0] swallow_val = '0;
  logic       mod_out, range_err;
  int         n_chk = 0, n_fail = 0;

  swallow_counter u0 (.clk(clk), .rst_n(rst_n), .ce(ce), .swallow_val(swallow_val),
    .band_hi(band_hi), .reload(reload), .mod_out(mod_out), .range_err(range_err));

  always #2.5 clk = ~clk;

  // {band_hi, swallow value, expected count length, expected error}
  localparam logic [13:0] VEC [9] = '{
    {1'b0, 6'd5,  6'd5,  1'b0},
    {1'b0, 6'd0,  6'd0,  1'b0},
    {1'b0, 6'd31, 6'd31, 1'b0},
    {1'b0, 6'd32, 6'd31, 1'b1},
    {1'b0, 6'd63, 6'd31, 1'b1},
    {1'b1, 6'd47, 6'd47, 1'b0},
    {1'b1, 6'd48, 6'd47, 1'b1},
    {1'b1, 6'd1,  6'd1,  1'b0},
    {1'b1, 6'd40, 6'd40, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic ld, input logic [5:0] s, input logic b);
    @(negedge clk);
    ce = c; reload = ld; swallow_val = s; band_hi = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0; reload = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 mod", int'(mod_out), 0);
    check("R1 err", int'(range_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_to_mod(output int n);
    n = 0;
    while (!mod_out && n < 70) begin
      step(1'b1, 1'b0, 6'd0, band_hi);
      n++;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    for (int k = 0; k < 9; k++) begin
      logic       b;
      logic [5:0] s, e;
      logic       er;
      {b, s, e, er} = VEC[k];
      do_reset();
      step(1'b1, 1'b1, s, b);
      check((e == 0) ? "R5 zero load mod" : "R2 load mod low", int'(mod_out), int'(e == 0));
      check("R7 err after load", int'(range_err), int'(er));
      count_to_mod(n);
      check("R3 R6 count length", n, int'(e));
      step(1'b1, 1'b0, 6'd9, b);
      step(1'b1, 1'b0, 6'd9, b);
      check("R4 mod held", int'(mod_out), 1);
      step(1'b0, 1'b1, 6'd9, b);
      check("R8 reload without ce", int'(mod_out), 1);
    end

    // R7 sticky across an in-range load; R1 clears it
    do_reset();
    step(1'b1, 1'b1, 6'd40, 1'b0);
    check("R7 set low band", int'(range_err), 1);
    step(1'b1, 1'b1, 6'd5, 1'b0);
    check("R7 sticky", int'(range_err), 1);
    do_reset();

    // R2 reload during a count restarts it
    step(1'b1, 1'b1, 6'd10, 1'b0);
    repeat (3) step(1'b1, 1'b0, 6'd0, 1'b0);
    step(1'b1, 1'b1, 6'd4, 1'b0);
    count_to_mod(n);
    check("R2 mid reload length", n, 4);

    // R3 R8 gaps in ce are not counted
    step(1'b1, 1'b1, 6'd3, 1'b0);
    n = 0;
    while (!mod_out && n < 20) begin
      step(1'b0, 1'b0, 6'd0, 1'b0);
      step(1'b0, 1'b0, 6'd0, 1'b0);
      step(1'b1, 1'b0, 6'd0, 1'b0);
      n++;
    end
    check("R3 gapped count", n, 3);

    // R8 reload with ce low neither loads nor sets err
    step(1'b0, 1'b1, 6'd50, 1'b0);
    check("R8 mod unchanged", int'(mod_out), 1);
    check("R8 err unchanged", int'(range_err), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule